// File: doc/BRIEF.md
# SDRAM command and refresh sequencer

This block drives the command pins of a single-data-rate SDRAM during setup and maintenance. A host writes a 32-bit configuration word through a plain write/read port. Part of that word sets the timing: precharge time, refresh-cycle time and CAS latency. Another part is a 3-bit command field. Writing a supported code into that field makes the sequencer issue one PRE-CHARGE, AUTO-REFRESH, mode-register load or extended-mode-register load. The sequencer then waits out the timing interval for that command and sets the field back to zero, which tells the host the command has finished.

Periodic auto-refresh comes from a reload counter. While the enable bit is set, a refresh request is raised once every (reload + 1) clocks. If a request arrives while a manual command is running, it is held and issued as soon as the sequencer returns to idle. Between commands the pins carry NOP. Each command is driven for exactly one clock.

Top module: `sdr_cmd_seq`

## Requirements
- R1: After reset, the configuration reads back as zero except for the two read-only bits (bit 16 = the MOBILE_CAP parameter, bit 15 = the WIDE_CAP parameter). The pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), with address and bank lines at zero.
- R2: Bits 16 and 15 always read back as their parameter values, whatever the host writes to them.
- R3: A command code in bits 20:18 issues one clock of the matching command. 010 gives PRE-CHARGE (pins 0010, address bit 10 high). 100 gives AUTO-REFRESH (pins 0001). 110 gives a mode load (pins 0000, bank 00). 111 gives an extended load (pins 0000, bank 10, address zero). The command appears one clock after the code is stored.
- R4: The command field returns to zero one clock before the sequencer can accept its next command, that is N-1 clocks after the command clock, where N is the command's interval.
- R5: After PRE-CHARGE, the next command comes no sooner than tRP clocks later. tRP is 2 when bit 30 is 0 and 3 when bit 30 is 1.
- R6: After any AUTO-REFRESH, the next command comes no sooner than tRFC = 3 + bits 29:27 clocks later.
- R7: A mode load drives burst length 8 on address bits 2:0 (011), a sequential burst on bit 3 (0), and a CAS latency on bits 6:4 of 010 when bit 26 is 0 or 011 when bit 26 is 1. Both load commands then wait tRCD clocks, which is 2 or 3 as set by bit 26.
- R8: While bit 31 is set, an AUTO-REFRESH request arises every (bits 14:0 + 1) clocks. The count restarts from the written value on every write with bit 31 set. While bit 31 is clear, no automatic refresh is requested.
- R9: A refresh request that arrives while a command is in progress is kept, and it is issued on the first idle clock. A pending refresh goes ahead of a waiting manual command. Requests that overlap merge into one pending refresh.
- R10: While the command field is non-zero, a host write leaves the field unchanged. The other writable bits still take the written value.
- R11: A non-zero code other than 010, 100, 110 or 111 issues no command and is cleared on the next idle clock.
- R12: In every clock that does not carry a command, the pins show NOP with address and bank at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 32 | Configuration word to write |
| cfg_rd_data | output | 32 | Current configuration word, including the read-only bits |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | 2 | SDRAM bank select (10 for the extended load) |
| sd_addr | output | ADDR_W | SDRAM address lines: bit 10 for precharge-all, low bits for the mode word |

## Verification
Each manual code is sent with both settings of the tRP and CAS bits and with several tRFC values, so an interval off by one clock shows up as a shifted next command or a late field clear. An unsupported code and a second code written during a busy interval show whether the field guard and the discard path hold. Periodic refresh runs with a small reload value, then with refresh disabled, which separates the (reload + 1) pacing from no pacing at all. A refresh timed to land inside a long manual refresh shows that the held request is issued later and not lost.

// File: rtl/sdr_seq_pkg.sv
// Package: shared field positions, pin encodings and helpers for the
// SDRAM command sequencer. Assumes a 32-bit configuration word.
package sdr_seq_pkg;

    localparam int CFG_W      = 32;
    localparam int RELOAD_W   = 15;
    localparam int B_REF_EN   = 31;
    localparam int B_TRP      = 30;
    localparam int B_TRFC_LO  = 27;
    localparam int B_CAS      = 26;
    localparam int B_CODE_LO  = 18;
    localparam int B_RO_MOB   = 16;
    localparam int B_RO_WIDE  = 15;
    localparam int CNT_W      = 4;

    // Command codes written by the host.
    localparam logic [2:0] CODE_PRE = 3'b010;
    localparam logic [2:0] CODE_REF = 3'b100;
    localparam logic [2:0] CODE_LMR = 3'b110;
    localparam logic [2:0] CODE_EMR = 3'b111;

    // Mode-word fields.
    localparam logic [2:0] MR_BL8 = 3'b011;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_pins_t;

    localparam sd_pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_pins_t PINS_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sd_pins_t PINS_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sd_pins_t PINS_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    // True for the four codes the sequencer executes.
    function automatic logic code_known(input logic [2:0] c);
        return (c == CODE_PRE) || (c == CODE_REF) || (c == CODE_LMR) || (c == CODE_EMR);
    endfunction

endpackage

// File: rtl/sdr_cfg_reg.sv
// Configuration word storage. Holds the writable fields and guards the
// self-clearing command field: a write cannot alter a non-zero code, and
// the engine's clear strobe zeroes it. Bits 16/15 are tied to parameters.
module sdr_cfg_reg
    import sdr_seq_pkg::*;
#(
    parameter bit MOBILE_CAP = 1'b0,
    parameter bit WIDE_CAP   = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             cmd_clear,
    output logic [CFG_W-1:0] cfg_q
);

    localparam logic [CFG_W-1:0] CODE_MASK = {{(CFG_W-3){1'b0}}, 3'b111} << B_CODE_LO;
    localparam logic [CFG_W-1:0] RO_MASK   = (CFG_W'(1) << B_RO_MOB) | (CFG_W'(1) << B_RO_WIDE);
    localparam logic [CFG_W-1:0] GEN_MASK  = ~(CODE_MASK | RO_MASK);

    logic [CFG_W-1:0] base_q;
    logic [2:0]       code_q;

    // Plain writable fields: take every host write.
    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else if (wr_en) base_q <= wr_data & GEN_MASK;
    end

    // Command field: clear wins, a write lands only while the field is empty.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else if (cmd_clear) code_q <= '0;
        else if (wr_en && code_q == 3'b000) code_q <= wr_data[B_CODE_LO +: 3];
    end

    // Read view: storage plus command field plus fixed capability bits.
    always_comb begin
        cfg_q                   = base_q;
        cfg_q[B_CODE_LO +: 3]   = code_q;
        cfg_q[B_RO_MOB]         = MOBILE_CAP;
        cfg_q[B_RO_WIDE]        = WIDE_CAP;
    end

    a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clear |=> (code_q == 3'b000));

    a_r10_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != 3'b000 && !cmd_clear) |=> $stable(code_q));

endmodule

// File: rtl/sdr_refresh_timer.sv
// Refresh pacing. A down-counter reloads from the host value on an enabling
// write and from the stored value each time it expires; expiry sets a
// pending flag that holds until the engine takes it.
module sdr_refresh_timer
    import sdr_seq_pkg::*;
#(
    parameter int RW = RELOAD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          reload_req,
    input  logic [RW-1:0] reload_new,
    input  logic [RW-1:0] reload_cur,
    input  logic          ref_taken,
    output logic          ref_pend
);

    logic [RW-1:0] cnt_q;
    logic          pend_q;
    logic          fire;

    assign fire     = enable && !reload_req && (cnt_q == '0);
    assign ref_pend = pend_q;

    // Counter: reload on write, wrap to the stored value on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (reload_req) cnt_q <= reload_new;
        else if (enable) cnt_q <= (cnt_q == '0) ? reload_cur : cnt_q - 1'b1;
    end

    // Pending flag: set on expiry, cleared only when the engine issues it.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else pend_q <= (pend_q && !ref_taken) || fire;
    end

    a_r9_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !ref_taken) |=> pend_q);

    a_r8_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !reload_req) |=> $stable(cnt_q));

endmodule

// File: rtl/sdr_cmd_engine.sv
// Command engine. From idle it starts a pending refresh first, else a known
// manual code; it drives the command for one clock, then NOP until the
// command's interval ends. Assumes ADDR_W >= 11 (bit 10 = precharge-all).
module sdr_cmd_engine
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trp_sel,
    input  logic [2:0]        trfc_field,
    input  logic              cas_sel,
    input  logic [2:0]        op_code,
    input  logic              ref_pend,
    output logic              ref_taken,
    output logic              cmd_clear,
    output sd_pins_t          pins,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr
);

    logic                busy_q, man_q;
    logic [CNT_W-1:0]    cnt_q;
    sd_pins_t            pins_q;
    logic [1:0]          ba_q;
    logic [ADDR_W-1:0]   addr_q;

    logic                start_man, drop_code;
    logic [CNT_W-1:0]    n_trp, n_trfc, n_rcd, man_len;
    sd_pins_t            man_pins;
    logic [1:0]          man_ba;
    logic [ADDR_W-1:0]   man_addr, mode_word;

    // Interval lengths from the configuration bits.
    always_comb begin
        n_trp  = trp_sel ? CNT_W'(3) : CNT_W'(2);
        n_trfc = CNT_W'(3) + CNT_W'(trfc_field);
        n_rcd  = cas_sel ? CNT_W'(3) : CNT_W'(2);
    end

    // Mode word: burst length 8, sequential burst, selected CAS latency.
    always_comb begin
        mode_word      = '0;
        mode_word[2:0] = MR_BL8;
        mode_word[6:4] = cas_sel ? 3'b011 : 3'b010;
    end

    // Idle decisions: refresh outranks a manual code.
    always_comb begin
        ref_taken = !busy_q && ref_pend;
        start_man = !busy_q && !ref_pend && code_known(op_code);
        drop_code = !busy_q && !ref_pend && (op_code != 3'b000) && !code_known(op_code);
        cmd_clear = (busy_q && man_q && cnt_q == CNT_W'(1)) || drop_code;
    end

    // Pin pattern, address and interval of the manual command.
    always_comb begin
        man_pins = PINS_NOP;
        man_addr = '0;
        man_ba   = 2'b00;
        man_len  = n_rcd;
        case (op_code)
            CODE_PRE: begin man_pins = PINS_PRE; man_addr[10] = 1'b1; man_len = n_trp; end
            CODE_REF: begin man_pins = PINS_REF; man_len = n_trfc; end
            CODE_LMR: begin man_pins = PINS_MRS; man_addr = mode_word; end
            CODE_EMR: begin man_pins = PINS_MRS; man_ba = 2'b10; end
            default:  ;
        endcase
    end

    // Sequencer state and registered pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            man_q  <= 1'b0;
            cnt_q  <= '0;
            pins_q <= PINS_NOP;
            ba_q   <= 2'b00;
            addr_q <= '0;
        end else if (ref_taken) begin
            busy_q <= 1'b1;
            man_q  <= 1'b0;
            cnt_q  <= n_trfc - 1'b1;
            pins_q <= PINS_REF;
            ba_q   <= 2'b00;
            addr_q <= '0;
        end else if (start_man) begin
            busy_q <= 1'b1;
            man_q  <= 1'b1;
            cnt_q  <= man_len - 1'b1;
            pins_q <= man_pins;
            ba_q   <= man_ba;
            addr_q <= man_addr;
        end else begin
            pins_q <= PINS_NOP;
            ba_q   <= 2'b00;
            addr_q <= '0;
            if (busy_q) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
            end
        end
    end

    assign pins = pins_q;
    assign ba   = ba_q;
    assign addr = addr_q;

    a_r12_nop_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> (pins_q == PINS_NOP));

    a_r3_single_clock_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_q != PINS_NOP) |=> (pins_q == PINS_NOP));

endmodule

// File: rtl/sdr_cmd_seq.sv
// Top: SDRAM command and refresh sequencer. Connects the configuration
// register, the refresh timer and the command engine. Assumes one clock
// domain and a host that polls the command field for completion.
module sdr_cmd_seq
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter bit MOBILE_CAP = 1'b0,
    parameter bit WIDE_CAP   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [31:0]       cfg_wr_data,
    output logic [31:0]       cfg_rd_data,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [1:0]        sd_ba,
    output logic [ADDR_W-1:0] sd_addr
);

    logic [CFG_W-1:0] cfg_q;
    logic             cmd_clear, ref_pend, ref_taken;
    sd_pins_t         pins;

    sdr_cfg_reg #(.MOBILE_CAP(MOBILE_CAP), .WIDE_CAP(WIDE_CAP)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_data   (cfg_wr_data),
        .cmd_clear (cmd_clear),
        .cfg_q     (cfg_q)
    );

    sdr_refresh_timer #(.RW(RELOAD_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_q[B_REF_EN]),
        .reload_req (cfg_wr_en && cfg_wr_data[B_REF_EN]),
        .reload_new (cfg_wr_data[RELOAD_W-1:0]),
        .reload_cur (cfg_q[RELOAD_W-1:0]),
        .ref_taken  (ref_taken),
        .ref_pend   (ref_pend)
    );

    sdr_cmd_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .trp_sel    (cfg_q[B_TRP]),
        .trfc_field (cfg_q[B_TRFC_LO +: 3]),
        .cas_sel    (cfg_q[B_CAS]),
        .op_code    (cfg_q[B_CODE_LO +: 3]),
        .ref_pend   (ref_pend),
        .ref_taken  (ref_taken),
        .cmd_clear  (cmd_clear),
        .pins       (pins),
        .ba         (sd_ba),
        .addr       (sd_addr)
    );

    assign cfg_rd_data = cfg_q;
    assign sd_cs_n     = pins.cs_n;
    assign sd_ras_n    = pins.ras_n;
    assign sd_cas_n    = pins.cas_n;
    assign sd_we_n     = pins.we_n;

endmodule

// File: tb/sdr_cmd_seq_bench.sv
// Bench: behavioural cycle model compared with the design after every clock,
// plus directed checks on reset, read-only bits and refresh counts.
module sdr_cmd_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [12:0] addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    string tag   = "R1";
    int ref_seen = 0;

    // Reference model state.
    logic [31:0] m_base;
    int          m_code, m_busy, m_cnt, m_man, m_pend, m_rcnt;
    logic [3:0]  m_pins;
    int          m_addr, m_ba;

    always #10 clk = ~clk;

    sdr_cmd_seq #(.ADDR_W(13), .MOBILE_CAP(1'b1), .WIDE_CAP(1'b0)) u_sdr_cmd_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_wr_data(wr_data),
        .cfg_rd_data(rd_data), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
        .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_ba(ba), .sd_addr(addr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance the model by one clock using the inputs now applied.
    task automatic model_step();
        int trp, trfc, rcd, rl, nl;
        bit known, sref, sman, bad, clr, rnow, fire;
        if (!rst_n) begin
            m_base = '0; m_code = 0; m_busy = 0; m_cnt = 0; m_man = 0;
            m_pend = 0; m_rcnt = 0; m_pins = 4'b0111; m_addr = 0; m_ba = 0;
            return;
        end
        trp   = m_base[30] ? 3 : 2;
        trfc  = 3 + int'(m_base[29:27]);
        rcd   = m_base[26] ? 3 : 2;
        rl    = int'(m_base[14:0]);
        known = (m_code == 2) || (m_code == 4) || (m_code == 6) || (m_code == 7);
        sref  = (m_busy == 0) && (m_pend != 0);
        sman  = (m_busy == 0) && (m_pend == 0) && known;
        bad   = (m_busy == 0) && (m_pend == 0) && (m_code != 0) && !known;
        clr   = ((m_busy != 0) && (m_cnt == 1) && (m_man != 0)) || bad;
        rnow  = wr_en && wr_data[31];
        fire  = m_base[31] && !rnow && (m_rcnt == 0);
        // refresh timer
        if (rnow) m_rcnt = int'(wr_data[14:0]);
        else if (m_base[31]) m_rcnt = (m_rcnt == 0) ? rl : m_rcnt - 1;
        m_pend = ((m_pend != 0) && !sref) || fire ? 1 : 0;
        // engine
        if (sref) begin
            m_pins = 4'b0001; m_addr = 0; m_ba = 0;
            m_busy = 1; m_man = 0; m_cnt = trfc - 1;
        end else if (sman) begin
            m_ba = 0; m_addr = 0; nl = rcd;
            case (m_code)
                2: begin m_pins = 4'b0010; m_addr = 1 << 10; nl = trp; end
                4: begin m_pins = 4'b0001; nl = trfc; end
                6: begin m_pins = 4'b0000; m_addr = 3 | ((m_base[26] ? 3 : 2) << 4); end
                default: begin m_pins = 4'b0000; m_ba = 2; end
            endcase
            m_busy = 1; m_man = 1; m_cnt = nl - 1;
        end else begin
            m_pins = 4'b0111; m_addr = 0; m_ba = 0;
            if (m_busy != 0) begin
                if (m_cnt == 1) m_busy = 0;
                m_cnt = m_cnt - 1;
            end
        end
        // configuration word
        if (clr) m_code = 0;
        else if (wr_en && m_code == 0) m_code = int'(wr_data[20:18]);
        if (wr_en) m_base = wr_data & 32'hFFE2_7FFF;
    endtask

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic tick();
        logic [31:0] exp_rd;
        @(posedge clk);
        model_step();
        @(negedge clk);
        exp_rd = m_base | (32'(m_code) << 18) | 32'h0001_0000;
        check({cs_n, ras_n, cas_n, we_n} == m_pins, tag, "pins",
              {cs_n, ras_n, cas_n, we_n}, m_pins);
        check(addr == 13'(m_addr) && ba == 2'(m_ba), tag, "addr/ba",
              {ba, addr}, {2'(m_ba), 13'(m_addr)});
        check(rd_data == exp_rd, tag, "cfg_rd_data", rd_data, exp_rd);
        if ({cs_n, ras_n, cas_n, we_n} == 4'b0001) ref_seen++;
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60; i++) begin
            if (m_busy == 0 && m_code == 0 && m_pend == 0) break;
            tick();
        end
        tick();
    endtask

    function automatic logic [31:0] cmdw(input logic [2:0] code, input logic [31:0] rest);
        return rest | (32'(code) << 18);
    endfunction

    initial begin
        run(3);
        rst_n = 1'b1;
        tick();
        tag = "R1";
        check(rd_data == 32'h0001_0000, "R1", "reset cfg", rd_data, 32'h0001_0000);
        check({cs_n, ras_n, cas_n, we_n} == 4'b0111 && addr == '0, "R1", "reset pins",
              {cs_n, ras_n, cas_n, we_n}, 4'b0111);

        tag = "R2";
        wr(32'h0000_8000);
        check(rd_data[16:15] == 2'b10, "R2", "read-only bits", rd_data[16:15], 2'b10);
        wr(32'h0000_0000);

        tag = "R5";
        wr(cmdw(3'b010, 32'h0));
        wait_idle();
        wr(cmdw(3'b010, 32'h4000_0000));
        run(1);
        wr(cmdw(3'b010, 32'h4000_0000));
        wait_idle();

        tag = "R6";
        wr(cmdw(3'b100, 32'h2800_0000));
        wait_idle();
        wr(cmdw(3'b100, 32'h0));
        wait_idle();

        tag = "R7";
        wr(cmdw(3'b110, 32'h0));
        check(rd_data[20:18] == 3'b110, "R7", "code stored", rd_data[20:18], 3'b110);
        tick();
        check(addr == 13'h023 && ba == 2'b00, "R7", "mode word cas2", addr, 13'h023);
        wait_idle();
        wr(cmdw(3'b110, 32'h0400_0000));
        tick();
        check(addr == 13'h033, "R7", "mode word cas3", addr, 13'h033);
        wait_idle();

        tag = "R3";
        wr(cmdw(3'b111, 32'h0400_0000));
        tick();
        check(ba == 2'b10 && {cs_n, ras_n, cas_n, we_n} == 4'b0000, "R3", "extended load",
              {ba, cs_n, ras_n, cas_n, we_n}, 6'b100000);
        wait_idle();

        tag = "R4";
        wr(cmdw(3'b010, 32'h4000_0000));
        tick();
        tick();
        check(rd_data[20:18] == 3'b010, "R4", "field busy", rd_data[20:18], 3'b010);
        tick();
        check(rd_data[20:18] == 3'b000, "R4", "field cleared", rd_data[20:18], 3'b000);
        wait_idle();

        tag = "R10";
        wr(cmdw(3'b100, 32'h3800_0000));
        wr(cmdw(3'b110, 32'h0000_0055));
        check(rd_data[20:18] == 3'b100 && rd_data[14:0] == 15'h55, "R10", "code guarded",
              rd_data, cmdw(3'b100, 32'h55));
        wait_idle();

        tag = "R11";
        wr(cmdw(3'b001, 32'h0));
        tick();
        check(rd_data[20:18] == 3'b000, "R11", "bad code cleared", rd_data[20:18], 3'b000);
        wr(cmdw(3'b101, 32'h0));
        wait_idle();

        tag = "R8";
        wr(32'h8000_0009);
        ref_seen = 0;
        run(40);
        check(ref_seen == 3, "R8", "refresh count", ref_seen, 3);
        wr(32'h0000_0009);
        ref_seen = 0;
        run(30);
        check(ref_seen == 0, "R8", "refresh disabled", ref_seen, 0);

        tag = "R9";
        wr(cmdw(3'b100, 32'hB800_0004));
        ref_seen = 0;
        run(30);
        check(ref_seen >= 3, "R9", "held refresh issued", ref_seen, 3);
        wr(cmdw(3'b010, 32'hB800_0002));
        run(40);
        wr(32'h0);
        wait_idle();

        tag = "R12";
        run(5);
        check({cs_n, ras_n, cas_n, we_n} == 4'b0111 && addr == '0, "R12", "idle NOP",
              {cs_n, ras_n, cas_n, we_n}, 4'b0111);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule